// File: doc/BRIEF.md
# Static Memory Bus Controller

This block runs single read and write cycles on an asynchronous static memory bus, such as SRAM, NOR flash or memory-mapped peripherals behind one chip select. A requester hands over an address, write data, byte enables and a direction with a valid/ready handshake. The controller then drives the active-low chip select, output enable, write enable and byte-lane selects, the address bus and the write data bus with its output enable. For a read it returns the captured data with a one-cycle response strobe.

Four 5-bit wait-state inputs set the strobe timing: how long output enable waits after chip select, where the read strobe ends, how long write enable waits and where the write strobe ends. A byte-mode input decides how the byte-lane selects behave. With byte mode on they frame the whole access. With it off they follow the write strobe. The wait-state and mode inputs are latched when a request is accepted, so they may change freely while a cycle runs.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and right after it, chip select, output enable, write enable and every byte-lane select are high, the data bus enable and response strobe are low, and ready is high.
- R2: Ready is high only while no access runs. A request accepted on a clock edge (valid and ready both high) pulls chip select low in the very next cycle, and chip select stays high for at least one cycle between two accesses.
- R3: In a read, output enable goes low `oen` cycles after chip select goes low, stays low for `rd - oen + 1` cycles, and rises together with chip select. Write enable stays high.
- R4: In a write, write enable goes low `1 + wen` cycles after chip select goes low and stays low for `wr - wen + 1` cycles. Chip select rises one cycle after write enable rises. Output enable stays high.
- R5: When `rd < oen` or `wr < wen`, the strobe pulse width is one cycle and the delays still follow R3 and R4.
- R6: With byte mode high in a write, byte-lane select i (driving data bits 8i+7 down to 8i) is low only when byte-enable bit i is 1. It is then low for `wr - wen + 3` cycles, starting `wen` cycles after chip select falls and rising together with chip select.
- R7: With byte mode high in a read, all byte-lane selects fall and rise together with chip select, whatever the byte enables.
- R8: With byte mode low, a write drives byte-lane select i low exactly in the cycles where write enable is low, for each lane whose byte-enable bit is 1. In a read all byte-lane selects stay high.
- R9: The address (and for a write, the write data) is valid from the first chip-select-low cycle and held until chip select rises. The data bus enable is high exactly during the chip-select-low cycles of a write.
- R10: Read data is sampled on the clock edge that ends the last output-enable-low cycle. It is presented with a response strobe that is high for exactly one cycle, the cycle after chip select rises. Writes give no response strobe.
- R11: Changing the wait-state inputs, byte mode, direction, address or data after a request is accepted has no effect on the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit i for data bits 8i+7:8i |
| cfg_wait_oen | input | 5 | Read strobe delay `oen` |
| cfg_wait_rd | input | 5 | Read strobe end `rd` |
| cfg_wait_wen | input | 5 | Write strobe delay `wen` |
| cfg_wait_wr | input | 5 | Write strobe end `wr` |
| cfg_byte_mode | input | 1 | Byte-lane select behaviour (R6 to R8) |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | DATA_W/8 | Byte-lane selects, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dout | output | DATA_W | Write data bus |
| mem_dout_en | output | 1 | Drive enable for the data bus |
| mem_din | input | DATA_W | Read data bus |

## Verification
Every memory-side strobe is registered, so the first chip-select-low cycle follows the accepting edge by one cycle. Each later strobe edge falls a fixed number of cycles after that first cycle, given by the latched wait-state values. The read response comes one cycle after chip select rises and carries the bus value from the last output-enable cycle. The bench's model expands each accepted request into one expected pin vector per cycle, counted from the cycle after acceptance. It compares that vector with the ports at every falling clock edge. It also changes the read bus each cycle, so a capture one cycle early or late shows up as a wrong response value.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   localparam int unsigned SBC_WS_W = 5;

   typedef logic [SBC_WS_W-1:0] sbc_ws_t;

   typedef struct packed {
      sbc_ws_t oen_dly;
      sbc_ws_t rd_end;
      sbc_ws_t wen_dly;
      sbc_ws_t wr_end;
      logic    byte_mode;
   } sbc_cfg_t;

endpackage

// File: rtl/sbc_timing.sv
// Turns the latched wait-state fields into cycle indices counted from the
// first chip-select-low cycle (index 0).
module sbc_timing
   import sbc_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  sbc_cfg_t         cfg,
   input  logic             is_wr,
   output logic [CNT_W-1:0] str_on,
   output logic [CNT_W-1:0] str_off,
   output logic [CNT_W-1:0] lane_on,
   output logic [CNT_W-1:0] last_idx
);

   logic [CNT_W-1:0] oen_x, rd_x, wen_x, wr_x;
   logic [CNT_W-1:0] rd_stop, wr_stop;

   always_comb begin
      oen_x   = CNT_W'(cfg.oen_dly);
      rd_x    = CNT_W'(cfg.rd_end);
      wen_x   = CNT_W'(cfg.wen_dly);
      wr_x    = CNT_W'(cfg.wr_end);
      // an end field below its delay collapses the pulse to one cycle
      rd_stop = (rd_x >= oen_x) ? rd_x : oen_x;
      wr_stop = ((wr_x >= wen_x) ? wr_x : wen_x) + CNT_W'(1);
      if (is_wr) begin
         str_on   = wen_x + CNT_W'(1);
         str_off  = wr_stop;
         lane_on  = wen_x;
         last_idx = wr_stop + CNT_W'(1);
      end else begin
         str_on   = oen_x;
         str_off  = rd_stop;
         lane_on  = '0;
         last_idx = rd_stop;
      end
   end

endmodule

// File: rtl/sbc_seq.sv
// Request acceptance, request latching and the cycle counter.
// Produces next-cycle state so the top can register every pin.
module sbc_seq
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   input  sbc_cfg_t          cfg_in,
   input  logic [CNT_W-1:0]  last_nxt,
   output logic              req_ready,
   output logic              busy_d,
   output logic [CNT_W-1:0]  cnt_d,
   output logic              is_wr_d,
   output sbc_cfg_t          cfg_d,
   output logic [LANES-1:0]  be_d,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              end_rd
);

   logic             busy_q, wr_q, accept, at_end;
   logic [CNT_W-1:0] cnt_q, last_q;
   sbc_cfg_t         cfg_q;
   logic [LANES-1:0] be_q;

   always_comb begin
      req_ready = ~busy_q;
      accept    = req_valid & ~busy_q;
      at_end    = busy_q & (cnt_q == last_q);
      end_rd    = at_end & ~wr_q;
      busy_d    = accept | (busy_q & ~at_end);
      cnt_d     = (busy_d & ~accept) ? cnt_q + CNT_W'(1) : '0;
      cfg_d     = accept ? cfg_in    : cfg_q;
      is_wr_d   = accept ? req_write : wr_q;
      be_d      = accept ? req_be    : be_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         last_q  <= '0;
         wr_q    <= 1'b0;
         cfg_q   <= '0;
         be_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         busy_q <= busy_d;
         cnt_q  <= cnt_d;
         cfg_q  <= cfg_d;
         wr_q   <= is_wr_d;
         be_q   <= be_d;
         if (accept) begin
            last_q  <= last_nxt;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

   // R2: a running access never outlasts its own end index
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= last_q));

endmodule

// File: rtl/sbc_strobe.sv
// Decodes next-cycle strobe levels (active high) from the next-cycle state.
module sbc_strobe #(
   parameter int unsigned LANES = 4,
   parameter int unsigned CNT_W = 8
) (
   input  logic             busy,
   input  logic             is_wr,
   input  logic             byte_mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] str_on,
   input  logic [CNT_W-1:0] str_off,
   input  logic [CNT_W-1:0] lane_on,
   input  logic [LANES-1:0] be,
   output logic             cs,
   output logic             oe,
   output logic             we,
   output logic             den,
   output logic [LANES-1:0] lane
);

   logic in_pulse, in_frame;

   always_comb begin
      in_pulse = (cnt >= str_on) && (cnt <= str_off);
      in_frame = cnt >= lane_on;
      cs       = busy;
      oe       = busy & ~is_wr & in_pulse;
      we       = busy &  is_wr & in_pulse;
      den      = busy &  is_wr;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         if (byte_mode)
            lane[i] = busy & (is_wr ? (be[i] & in_frame) : 1'b1);
         else
            lane[i] = we & be[i];
      end
   end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_be,
   input  logic [SBC_WS_W-1:0]   cfg_wait_oen,
   input  logic [SBC_WS_W-1:0]   cfg_wait_rd,
   input  logic [SBC_WS_W-1:0]   cfg_wait_wen,
   input  logic [SBC_WS_W-1:0]   cfg_wait_wr,
   input  logic                  cfg_byte_mode,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic                  mem_cs_n,
   output logic                  mem_oe_n,
   output logic                  mem_we_n,
   output logic [DATA_W/8-1:0]   mem_bls_n,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_dout,
   output logic                  mem_dout_en,
   input  logic [DATA_W-1:0]     mem_din
);

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned CNT_W = SBC_WS_W + 3;

   if (DATA_W == 0 || DATA_W % 8 != 0) begin : g_bad_data_w
      $error("sram_bus_ctrl: DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W == 0) begin : g_bad_addr_w
      $error("sram_bus_ctrl: ADDR_W must be non-zero");
   end

   sbc_cfg_t         cfg_in, cfg_d;
   logic             busy_d, is_wr_d, end_rd;
   logic [CNT_W-1:0] cnt_d, str_on, str_off, lane_on, last_nxt;
   logic [LANES-1:0] be_d, lane_d;
   logic             cs_d, oe_d, we_d, den_d;

   always_comb begin
      cfg_in.oen_dly   = cfg_wait_oen;
      cfg_in.rd_end    = cfg_wait_rd;
      cfg_in.wen_dly   = cfg_wait_wen;
      cfg_in.wr_end    = cfg_wait_wr;
      cfg_in.byte_mode = cfg_byte_mode;
   end

   sbc_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .cfg_in    (cfg_in),
      .last_nxt  (last_nxt),
      .req_ready (req_ready),
      .busy_d    (busy_d),
      .cnt_d     (cnt_d),
      .is_wr_d   (is_wr_d),
      .cfg_d     (cfg_d),
      .be_d      (be_d),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dout),
      .end_rd    (end_rd)
   );

   sbc_timing #(.CNT_W(CNT_W)) u_timing (
      .cfg      (cfg_d),
      .is_wr    (is_wr_d),
      .str_on   (str_on),
      .str_off  (str_off),
      .lane_on  (lane_on),
      .last_idx (last_nxt)
   );

   sbc_strobe #(.LANES(LANES), .CNT_W(CNT_W)) u_strobe (
      .busy      (busy_d),
      .is_wr     (is_wr_d),
      .byte_mode (cfg_d.byte_mode),
      .cnt       (cnt_d),
      .str_on    (str_on),
      .str_off   (str_off),
      .lane_on   (lane_on),
      .be        (be_d),
      .cs        (cs_d),
      .oe        (oe_d),
      .we        (we_d),
      .den       (den_d),
      .lane      (lane_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_cs_n    <= 1'b1;
         mem_oe_n    <= 1'b1;
         mem_we_n    <= 1'b1;
         mem_bls_n   <= '1;
         mem_dout_en <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         mem_cs_n    <= ~cs_d;
         mem_oe_n    <= ~oe_d;
         mem_we_n    <= ~we_d;
         mem_bls_n   <= ~lane_d;
         mem_dout_en <= den_d;
         rsp_valid   <= end_rd;
         if (end_rd) rsp_rdata <= mem_din;
      end
   end

   // R5: the decoded pulse window is never empty, whatever the fields hold
   assert_pulse_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_d |-> (str_off >= str_on));

   // R2: no acceptance while chip select is active
   assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);

   // R2: an accepted request shows chip select in the next cycle
   assert_accept_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !mem_cs_n);

   // R3: the two strobes never overlap
   assert_oe_we_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> mem_we_n);

   // R4: write enable only falls after chip select has been low a cycle
   assert_we_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(!mem_cs_n));

   // R4: chip select rises one cycle after write enable rises
   assert_cs_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_cs_n ##1 mem_cs_n));

   // R9: data bus only driven inside an access
   assert_den_in_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dout_en |-> !mem_cs_n);

   // R9: address held while chip select stays low
   assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   // R10: response strobe is a single-cycle pulse outside chip select
   assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (mem_cs_n && $past(!mem_cs_n)) ##1 !rsp_valid);

endmodule

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;

   localparam int AW = 24;
   localparam int DW = 32;
   localparam int LN = 4;

   typedef struct packed {
      logic          cs_n;
      logic          oe_n;
      logic          we_n;
      logic [LN-1:0] bls_n;
      logic          den;
      logic          rdy;
      logic          rsp;
      logic          lastrd;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [LN-1:0] req_be = '0;
   logic [4:0]    cfg_wait_oen = '0, cfg_wait_rd = '0, cfg_wait_wen = '0, cfg_wait_wr = '0;
   logic          cfg_byte_mode = 1'b0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
   logic [LN-1:0] mem_bls_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout;
   logic [DW-1:0] mem_din = '0;

   exp_t   q[$];
   int     n_chk = 0;
   int     n_fail = 0;
   int     cyc = 0;
   logic   last_ready = 1'b1;
   logic [DW-1:0] exp_rdata = '0;
   string  tag = "R1";
   string  lane_req = "R1";

   always #5 clk = ~clk;

   sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_sram_bus_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .cfg_wait_oen(cfg_wait_oen), .cfg_wait_rd(cfg_wait_rd),
      .cfg_wait_wen(cfg_wait_wen), .cfg_wait_wr(cfg_wait_wr),
      .cfg_byte_mode(cfg_byte_mode),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_bls_n(mem_bls_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_dout_en(mem_dout_en), .mem_din(mem_din)
   );

   function automatic exp_t idle_entry(logic rsp);
      exp_t e;
      e = '0;
      e.cs_n = 1'b1; e.oe_n = 1'b1; e.we_n = 1'b1; e.bls_n = '1;
      e.rdy = 1'b1; e.rsp = rsp;
      return e;
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] %s cycle %0d: actual %0h expected %0h",
                  (tag == "R1") ? "R1" : req, tag, what, cyc, act, exp);
      end
   endtask

   task automatic tick();
      exp_t e;
      @(negedge clk);
      cyc++;
      e = (q.size() > 0) ? q.pop_front() : idle_entry(1'b0);
      chk("R2",  "cs_n",    64'(mem_cs_n),    64'(e.cs_n));
      chk("R2",  "ready",   64'(req_ready),   64'(e.rdy));
      chk("R3",  "oe_n",    64'(mem_oe_n),    64'(e.oe_n));
      chk("R4",  "we_n",    64'(mem_we_n),    64'(e.we_n));
      chk(lane_req, "bls_n", 64'(mem_bls_n),  64'(e.bls_n));
      chk("R9",  "dout_en", 64'(mem_dout_en), 64'(e.den));
      if (!e.cs_n) chk("R9", "addr", 64'(mem_addr), 64'(e.addr));
      if (e.den)   chk("R9", "dout", 64'(mem_dout), 64'(e.wdata));
      chk("R10", "rsp_valid", 64'(rsp_valid), 64'(e.rsp));
      if (e.rsp)   chk("R10", "rdata", 64'(rsp_rdata), 64'(exp_rdata));
      last_ready = e.rdy;
      mem_din = 32'h5A3C0000 ^ (32'(cyc) * 32'h00010307);
      if (e.lastrd) exp_rdata = mem_din;
   endtask

   task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [LN-1:0] be, input int oen, input int rd,
                        input int wen, input int wre, input logic pb, input logic scramble);
      int on, off, lon, last;
      exp_t e;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      cfg_wait_oen = 5'(oen); cfg_wait_rd = 5'(rd);
      cfg_wait_wen = 5'(wen); cfg_wait_wr = 5'(wre); cfg_byte_mode = pb;
      while (!last_ready) tick();
      if (wr) begin
         on = wen + 1; off = ((wre >= wen) ? wre : wen) + 1; lon = wen; last = off + 1;
      end else begin
         on = oen; off = (rd >= oen) ? rd : oen; lon = 0; last = off;
      end
      for (int t = 0; t <= last; t++) begin
         e = '0;
         e.cs_n = 1'b0;
         e.oe_n = !(!wr && t >= on && t <= off);
         e.we_n = !( wr && t >= on && t <= off);
         for (int i = 0; i < LN; i++) begin
            if (pb) e.bls_n[i] = wr ? !(be[i] && t >= lon) : 1'b0;
            else    e.bls_n[i] = wr ? !(be[i] && t >= on && t <= off) : 1'b1;
         end
         e.den = wr; e.rdy = 1'b0; e.rsp = 1'b0;
         e.lastrd = !wr && (t == last);
         e.addr = a; e.wdata = d;
         q.push_back(e);
      end
      q.push_back(idle_entry(!wr));
      tick();
      req_valid = 1'b0;
      if (scramble) begin
         req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_be = ~be;
         cfg_wait_oen = 5'd31; cfg_wait_rd = 5'd0;
         cfg_wait_wen = 5'd31; cfg_wait_wr = 5'd0; cfg_byte_mode = ~pb;
      end
      while (q.size() > 1) tick();
   endtask

   initial begin
      // R1: reset state
      tag = "R1"; lane_req = "R1";
      repeat (3) tick();
      rst_n = 1'b1;
      repeat (2) tick();

      // R3, R7: byte-mode read
      tag = "R3"; lane_req = "R7";
      issue(1'b0, 24'h001234, '0, 4'b0000, 2, 5, 0, 0, 1'b1, 1'b0);
      // R4, R6: byte-mode write, two lanes
      tag = "R4"; lane_req = "R6";
      issue(1'b1, 24'h00ABCD, 32'hDEADBEEF, 4'b0101, 0, 0, 1, 4, 1'b1, 1'b0);
      // R6: wen = 0 so lanes match chip select
      tag = "R6"; lane_req = "R6";
      issue(1'b1, 24'h000010, 32'h01234567, 4'b1111, 0, 0, 0, 2, 1'b1, 1'b0);
      // R8: non-byte-mode write, lanes follow write enable
      tag = "R8"; lane_req = "R8";
      issue(1'b1, 24'h3F0002, 32'hCAFEF00D, 4'b1010, 0, 0, 0, 0, 1'b0, 1'b0);
      // R8, R10: non-byte-mode minimal read
      tag = "R10"; lane_req = "R8";
      issue(1'b0, 24'h3F0004, '0, 4'b1111, 0, 0, 0, 0, 1'b0, 1'b0);
      // R5: clamped read and write widths
      tag = "R5"; lane_req = "R6";
      issue(1'b0, 24'h000100, '0, 4'b0011, 6, 2, 0, 0, 1'b1, 1'b0);
      issue(1'b1, 24'h000104, 32'h11223344, 4'b0011, 0, 0, 5, 1, 1'b1, 1'b0);
      // R2: back-to-back read then write then read
      tag = "R2"; lane_req = "R7";
      issue(1'b0, 24'h0A0A0A, '0, 4'b0000, 1, 1, 0, 0, 1'b1, 1'b0);
      lane_req = "R6";
      issue(1'b1, 24'h0B0B0B, 32'h89ABCDEF, 4'b1000, 0, 0, 2, 3, 1'b1, 1'b0);
      lane_req = "R7";
      issue(1'b0, 24'h0C0C0C, '0, 4'b0000, 0, 3, 0, 0, 1'b1, 1'b0);
      // R11: inputs change after acceptance
      tag = "R11"; lane_req = "R6";
      issue(1'b1, 24'h123456, 32'h0F0F0F0F, 4'b0110, 0, 0, 2, 6, 1'b1, 1'b1);
      lane_req = "R7";
      issue(1'b0, 24'h654321, '0, 4'b0000, 3, 7, 0, 0, 1'b1, 1'b1);
      // long wait states
      tag = "R3"; lane_req = "R8";
      issue(1'b0, 24'hFFFFFF, '0, 4'b1111, 31, 31, 0, 0, 1'b0, 1'b0);
      tag = "R4"; lane_req = "R8";
      issue(1'b1, 24'h000000, 32'hFFFFFFFF, 4'b1111, 0, 0, 31, 31, 1'b0, 1'b0);
      tag = "R2"; lane_req = "R2";
      repeat (4) tick();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule